// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block is the coherence controller of one private, direct-mapped cache on a shared snooping bus. Several instances sit on the same bus. Each line is in one of four valid states or is invalid:

- sole clean copy
- shared clean copy
- shared dirty copy, which makes this cache the owner responsible for memory
- sole dirty copy

When a processor writes to a line that other caches also hold, the new word is broadcast on the bus and every holder merges it into its copy. No copy is ever invalidated. A wired-OR shared signal, driven by every cache that holds the addressed line, tells the requester whether other copies exist. Main memory is written only when a dirty line is evicted.

The processor side is a request/response stream pair.

- **Requests:** a request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` is low while an operation is in progress, and also during any cycle in which another cache owns the bus.
- **Responses:** `cpu_rsp_valid` stays high, with `cpu_rsp_rdata` unchanged, until `cpu_rsp_ready` is seen high. For a write, the response carries the word that was written.

The bus side is atomic. A granted transaction completes in the single cycle of its grant. In that same cycle the snoopers answer through `snp_shared_o`, `snp_supply_o` and `snp_data_o`, and the environment ORs these answers together and returns the line word on `bus_data_i`.

Top module: `wupd_cache_ctrl`

## Requirements
- R1: After reset every line is invalid: `cpu_req_ready` is high, `cpu_rsp_valid` and `bus_req_o` are low, and the first access to any address misses.
- R2: A read miss issues one bus read (command code 1). The line is filled with `bus_data_i`, and that word is returned. The line becomes shared-clean if `bus_shared_i` was high in the grant cycle, and exclusive-clean otherwise.
- R3: A write hit on an exclusive-clean or modified line completes with no bus transaction and leaves the line modified.
- R4: A write hit on a shared-clean or shared-dirty line issues one bus update (command code 2) carrying the address and the new word. The line ends shared-dirty if `bus_shared_i` was high in the grant cycle, and modified if it was low. The response follows in the next cycle.
- R5: A cache that holds a line snooped by a foreign bus update asserts `snp_shared_o`, writes the broadcast word into its copy and keeps the line valid as shared-clean.
- R6: A cache that holds a line snooped by a foreign bus read asserts `snp_shared_o`. If its copy is dirty it also asserts `snp_supply_o` with the word on `snp_data_o`. An exclusive-clean copy becomes shared-clean; a modified copy becomes shared-dirty.
- R7: A write miss first issues a bus read. If the line is not shared, the word is written locally and the line becomes modified. If it is shared, a bus update with the word follows.
- R8: A miss whose victim is dirty first issues a write-back (command code 3) of the victim's address and word, and then the bus read. A clean victim is dropped with no bus transaction.
- R9: A response is held stable until accepted. `cpu_req_ready` is low while an operation is pending and during any foreign bus cycle.
- R10: `bus_cmd_o` is nonzero (0 idle) only while granted. `bus_req_o` and `bus_addr_o` hold until the grant. A cache never answers its own transaction.
- R11: After any sequence of operations, a read of an address through any cache returns the last word written to it by any cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Request can be taken |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address |
| cpu_req_wdata | input | DW | Write word |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | Response accepted |
| cpu_rsp_rdata | output | DW | Read word or written word |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant for this cycle |
| bus_cmd_o | output | 2 | Own command: 0 idle, 1 read, 2 update, 3 write-back |
| bus_addr_o | output | AW | Own transaction address |
| bus_data_o | output | DW | Update word or write-back word |
| bus_valid_i | input | 1 | A transaction is on the bus |
| bus_cmd_i | input | 2 | Command on the bus |
| bus_addr_i | input | AW | Address on the bus |
| bus_data_i | input | DW | Word on the bus (fill data for reads) |
| bus_shared_i | input | 1 | Wired-OR of all shared answers |
| snp_shared_o | output | 1 | This cache holds the snooped line |
| snp_supply_o | output | 1 | This cache supplies the read word |
| snp_data_o | output | DW | Supplied word |

## Verification
The bound checker watches the protocol rules on every cycle:

- a dirty snooper always also claims sharing;
- a cache never answers its own transaction;
- commands appear only under grant;
- requests stay stable until granted;
- a write-back is always followed by a read request;
- an update is always followed by a response;
- responses are held stable until accepted;
- no request is taken during a foreign bus cycle.

The state that a line ends in cannot be seen on any port, so only the bench's scenarios can show it. Each operation in its three-cache sequence has an expected count of reads, updates and write-backs that reveals the line state (a silent write proves modified, for example). The words returned through every cache are checked against a model of the last write.

// File: rtl/wupd_pkg.sv
package wupd_pkg;
  typedef enum logic [2:0] {
    LS_INV, LS_EC, LS_SC, LS_SM, LS_MOD
  } line_state_t;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0, BC_READ = 2'd1, BC_UPDATE = 2'd2, BC_WBACK = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WB, ST_RD, ST_UPD, ST_RESP
  } ctrl_state_t;

  function automatic logic is_dirty(line_state_t s);
    return (s == LS_SM) || (s == LS_MOD);
  endfunction
endpackage

// File: rtl/wupd_line_store.sv
module wupd_line_store
  import wupd_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  parameter int DW    = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output line_state_t      ra_st,
  output logic [TAG_W-1:0] ra_tag,
  output logic [DW-1:0]    ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output line_state_t      rb_st,
  output logic [TAG_W-1:0] rb_tag,
  output logic [DW-1:0]    rb_data,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  line_state_t      w_st,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [DW-1:0]    w_data
);
  line_state_t      st_q   [SETS];
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [DW-1:0]    data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LS_INV;
    end else if (we) begin
      st_q[w_idx] <= w_st;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[w_idx]  <= w_tag;
      data_q[w_idx] <= w_data;
    end
  end

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];
endmodule

// File: rtl/wupd_snoop_resp.sv
module wupd_snoop_resp
  import wupd_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int DW    = 16
) (
  input  logic             act,
  input  bus_cmd_t         cmd,
  input  logic [TAG_W-1:0] bus_tag,
  input  logic [DW-1:0]    bus_data,
  input  line_state_t      ln_st,
  input  logic [TAG_W-1:0] ln_tag,
  input  logic [DW-1:0]    ln_data,
  output logic             shared,
  output logic             supply,
  output logic [DW-1:0]    supply_data,
  output logic             we,
  output line_state_t      new_st,
  output logic [DW-1:0]    new_data
);
  logic hit;

  always_comb begin
    hit      = act && (ln_st != LS_INV) && (ln_tag == bus_tag);
    shared   = 1'b0;
    supply   = 1'b0;
    we       = 1'b0;
    new_st   = ln_st;
    new_data = ln_data;
    if (hit) begin
      case (cmd)
        BC_READ: begin
          // holder answers; a dirty holder sources the word and stays owner
          shared = 1'b1;
          supply = is_dirty(ln_st);
          if (ln_st == LS_EC) begin
            we = 1'b1; new_st = LS_SC;
          end else if (ln_st == LS_MOD) begin
            we = 1'b1; new_st = LS_SM;
          end
        end
        BC_UPDATE: begin
          // merge broadcast word; ownership passes to the writer
          shared   = 1'b1;
          we       = 1'b1;
          new_st   = LS_SC;
          new_data = bus_data;
        end
        default: ;
      endcase
    end
    supply_data = supply ? ln_data : '0;
  end
endmodule

// File: rtl/wupd_cache_ctrl.sv
module wupd_cache_ctrl
  import wupd_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int SETS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req_valid,
  output logic          cpu_req_ready,
  input  logic          cpu_req_write,
  input  logic [AW-1:0] cpu_req_addr,
  input  logic [DW-1:0] cpu_req_wdata,
  output logic          cpu_rsp_valid,
  input  logic          cpu_rsp_ready,
  output logic [DW-1:0] cpu_rsp_rdata,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [1:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  input  logic          bus_valid_i,
  input  logic [1:0]    bus_cmd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_shared_i,
  output logic          snp_shared_o,
  output logic          snp_supply_o,
  output logic [DW-1:0] snp_data_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W;

  ctrl_state_t      st_q, st_d;
  logic             op_wr_q;
  logic [AW-1:0]    op_addr_q;
  logic [DW-1:0]    op_wdata_q, rsp_q, rsp_d;

  logic [AW-1:0]    lk_addr;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_want, lk_tag, sn_tag;
  line_state_t      lk_st, sn_st, fw_st, sw_st, w_st;
  logic [DW-1:0]    lk_data, sn_data, fw_data, sw_data, w_data;
  logic             lk_hit, foreign, accept, granted, fw_we, sw_we;
  logic [TAG_W-1:0] fw_tag;
  bus_cmd_t         cmd_sel;

  assign foreign       = bus_valid_i && !bus_gnt_i;
  assign cpu_req_ready = (st_q == ST_IDLE) && !foreign;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign lk_addr       = (st_q == ST_IDLE) ? cpu_req_addr : op_addr_q;
  assign lk_idx        = lk_addr[IDX_W-1:0];
  assign lk_want       = lk_addr[AW-1:IDX_W];
  assign lk_hit        = (lk_st != LS_INV) && (lk_tag == lk_want);
  assign bus_req_o     = (st_q == ST_WB) || (st_q == ST_RD) || (st_q == ST_UPD);
  assign granted       = bus_gnt_i && bus_req_o;

  wupd_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DW(DW)) u_store (
    .clk, .rst_n,
    .ra_idx(lk_idx), .ra_st(lk_st), .ra_tag(lk_tag), .ra_data(lk_data),
    .rb_idx(bus_addr_i[IDX_W-1:0]), .rb_st(sn_st), .rb_tag(sn_tag), .rb_data(sn_data),
    .we(fw_we || sw_we), .w_idx(sw_we ? bus_addr_i[IDX_W-1:0] : lk_idx),
    .w_st(w_st), .w_tag(sw_we ? sn_tag : fw_tag), .w_data(w_data)
  );

  wupd_snoop_resp #(.TAG_W(TAG_W), .DW(DW)) u_snoop (
    .act(foreign), .cmd(bus_cmd_t'(bus_cmd_i)),
    .bus_tag(bus_addr_i[AW-1:IDX_W]), .bus_data(bus_data_i),
    .ln_st(sn_st), .ln_tag(sn_tag), .ln_data(sn_data),
    .shared(snp_shared_o), .supply(snp_supply_o), .supply_data(snp_data_o),
    .we(sw_we), .new_st(sw_st), .new_data(sw_data)
  );

  // snoop writes and own writes never coincide: own writes need a quiet or granted cycle
  assign w_st   = sw_we ? sw_st : fw_st;
  assign w_data = sw_we ? sw_data : fw_data;

  always_comb begin
    st_d    = st_q;
    rsp_d   = rsp_q;
    fw_we   = 1'b0;
    fw_st   = lk_st;
    fw_tag  = lk_want;
    fw_data = lk_data;
    case (st_q)
      ST_IDLE: if (accept) begin
        if (lk_hit) begin
          if (!cpu_req_write) begin
            rsp_d = lk_data;
            st_d  = ST_RESP;
          end else if (lk_st == LS_EC || lk_st == LS_MOD) begin
            fw_we = 1'b1; fw_st = LS_MOD; fw_data = cpu_req_wdata;
            rsp_d = cpu_req_wdata;
            st_d  = ST_RESP;
          end else begin
            st_d = ST_UPD;
          end
        end else begin
          st_d = is_dirty(lk_st) ? ST_WB : ST_RD;
        end
      end
      ST_WB: if (granted) begin
        fw_we = 1'b1; fw_st = LS_INV; fw_tag = lk_tag;
        st_d  = ST_RD;
      end
      ST_RD: if (granted) begin
        fw_we   = 1'b1;
        fw_data = bus_data_i;
        if (!op_wr_q) begin
          fw_st = bus_shared_i ? LS_SC : LS_EC;
          rsp_d = bus_data_i;
          st_d  = ST_RESP;
        end else if (bus_shared_i) begin
          fw_st = LS_SC;
          st_d  = ST_UPD;
        end else begin
          fw_st = LS_MOD; fw_data = op_wdata_q;
          rsp_d = op_wdata_q;
          st_d  = ST_RESP;
        end
      end
      ST_UPD: if (granted) begin
        fw_we = 1'b1; fw_data = op_wdata_q;
        fw_st = bus_shared_i ? LS_SM : LS_MOD;
        rsp_d = op_wdata_q;
        st_d  = ST_RESP;
      end
      ST_RESP: if (cpu_rsp_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_wr_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rsp_q      <= '0;
    end else begin
      st_q  <= st_d;
      rsp_q <= rsp_d;
      if (accept) begin
        op_wr_q    <= cpu_req_write;
        op_addr_q  <= cpu_req_addr;
        op_wdata_q <= cpu_req_wdata;
      end
    end
  end

  always_comb begin
    case (st_q)
      ST_WB:   cmd_sel = BC_WBACK;
      ST_RD:   cmd_sel = BC_READ;
      ST_UPD:  cmd_sel = BC_UPDATE;
      default: cmd_sel = BC_NONE;
    endcase
  end

  assign bus_cmd_o     = bus_gnt_i ? cmd_sel : BC_NONE;
  assign bus_addr_o    = (st_q == ST_WB) ? {lk_tag, lk_idx} : op_addr_q;
  assign bus_data_o    = (st_q == ST_WB) ? lk_data : op_wdata_q;
  assign cpu_rsp_valid = (st_q == ST_RESP);
  assign cpu_rsp_rdata = rsp_q;
endmodule

// File: rtl/wupd_cache_chk.sv
module wupd_cache_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_ready,
  input logic          cpu_rsp_valid,
  input logic          cpu_rsp_ready,
  input logic [DW-1:0] cpu_rsp_rdata,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic [1:0]    bus_cmd_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_valid_i,
  input logic          snp_shared_o,
  input logic          snp_supply_o
);
  p_update_then_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt_i && bus_cmd_o == 2'd2) |=> cpu_rsp_valid);

  p_supply_claims_shared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply_o |-> snp_shared_o);

  p_wback_then_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt_i && bus_cmd_o == 2'd3) |=> bus_req_o);

  p_rsp_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata)));

  p_quiet_on_foreign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_i && !bus_gnt_i) |-> !cpu_req_ready);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o)));

  p_no_self_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt_i |-> (!snp_shared_o && !snp_supply_o));

  p_granted_has_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt_i && bus_req_o) |-> (bus_cmd_o != 2'd0));
endmodule

bind wupd_cache_ctrl wupd_cache_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/wupd_cache_ctrl_bench.sv
module wupd_cache_ctrl_bench;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LIMIT = 20000;

  typedef struct packed {
    logic [1:0]    c;
    logic          wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [1:0]    nrd;
    logic [1:0]    nupd;
    logic [1:0]    nwb;
  } vec_t;

  // cache, write, addr, word, expected reads / updates / write-backs (sets = 4)
  localparam vec_t VEC [19] = '{
    '{2'd0, 1'b0, 8'h10, 16'h0000, 2'd1, 2'd0, 2'd0}, // R2 miss, alone -> EC
    '{2'd0, 1'b1, 8'h10, 16'hA001, 2'd0, 2'd0, 2'd0}, // R3 EC write silent
    '{2'd0, 1'b1, 8'h10, 16'hB002, 2'd0, 2'd0, 2'd0}, // R3 M write silent
    '{2'd1, 1'b0, 8'h10, 16'h0000, 2'd1, 2'd0, 2'd0}, // R6 c0 supplies
    '{2'd2, 1'b0, 8'h10, 16'h0000, 2'd1, 2'd0, 2'd0}, // R6 owner still supplies
    '{2'd1, 1'b1, 8'h10, 16'hC003, 2'd0, 2'd1, 2'd0}, // R4 shared write
    '{2'd0, 1'b0, 8'h10, 16'h0000, 2'd0, 2'd0, 2'd0}, // R5 merged copy
    '{2'd2, 1'b0, 8'h10, 16'h0000, 2'd0, 2'd0, 2'd0}, // R5 merged copy
    '{2'd0, 1'b1, 8'h14, 16'hD004, 2'd1, 2'd0, 2'd0}, // R7 R8 clean victim
    '{2'd1, 1'b0, 8'h14, 16'h0000, 2'd1, 2'd0, 2'd1}, // R8 dirty victim
    '{2'd2, 1'b0, 8'h10, 16'h0000, 2'd0, 2'd0, 2'd0}, // R5 hit
    '{2'd2, 1'b1, 8'h10, 16'hE005, 2'd0, 2'd1, 2'd0}, // R4 no sharer -> M
    '{2'd2, 1'b1, 8'h10, 16'hF006, 2'd0, 2'd0, 2'd0}, // R3 proves M
    '{2'd2, 1'b1, 8'h11, 16'h1007, 2'd1, 2'd0, 2'd0}, // R7 unshared miss
    '{2'd0, 1'b1, 8'h11, 16'h2008, 2'd1, 2'd1, 2'd0}, // R7 shared miss
    '{2'd2, 1'b0, 8'h11, 16'h0000, 2'd0, 2'd0, 2'd0}, // R5 hit merged
    '{2'd1, 1'b0, 8'h11, 16'h0000, 2'd1, 2'd0, 2'd0}, // R6 shared-dirty supplies
    '{2'd0, 1'b0, 8'h14, 16'h0000, 2'd0, 2'd0, 2'd0}, // R2 hit
    '{2'd0, 1'b0, 8'h10, 16'h0000, 2'd1, 2'd0, 2'd1}  // R8 wb then read
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rq_v [NC], rq_r [NC], rq_w [NC], rs_v [NC], rs_r [NC];
  logic [AW-1:0] rq_a [NC];
  logic [DW-1:0] rq_d [NC], rs_d [NC];
  logic [NC-1:0] breq, bgnt, bshr, bsup;
  logic [1:0]    cmd_o [NC];
  logic [AW-1:0] addr_o [NC];
  logic [DW-1:0] dat_o [NC], sdat [NC];
  logic          bvalid;
  logic [1:0]    bcmd;
  logic [AW-1:0] baddr;
  logic [DW-1:0] bwdat, bdata, supdat;
  logic [DW-1:0] mem  [256];
  logic [DW-1:0] gold [256];
  int n_rd, n_upd, n_wb, bad_cmd, cyc;
  int total = 0, fails = 0;

  for (genvar g = 0; g < NC; g++) begin : g_c
    if (g == 0) begin : g_dut
      wupd_cache_ctrl u_wupd_cache_ctrl (
        .clk, .rst_n,
        .cpu_req_valid(rq_v[g]), .cpu_req_ready(rq_r[g]), .cpu_req_write(rq_w[g]),
        .cpu_req_addr(rq_a[g]), .cpu_req_wdata(rq_d[g]),
        .cpu_rsp_valid(rs_v[g]), .cpu_rsp_ready(rs_r[g]), .cpu_rsp_rdata(rs_d[g]),
        .bus_req_o(breq[g]), .bus_gnt_i(bgnt[g]), .bus_cmd_o(cmd_o[g]),
        .bus_addr_o(addr_o[g]), .bus_data_o(dat_o[g]),
        .bus_valid_i(bvalid), .bus_cmd_i(bcmd), .bus_addr_i(baddr), .bus_data_i(bdata),
        .bus_shared_i(|bshr),
        .snp_shared_o(bshr[g]), .snp_supply_o(bsup[g]), .snp_data_o(sdat[g]));
    end else begin : g_peer
      wupd_cache_ctrl u_peer (
        .clk, .rst_n,
        .cpu_req_valid(rq_v[g]), .cpu_req_ready(rq_r[g]), .cpu_req_write(rq_w[g]),
        .cpu_req_addr(rq_a[g]), .cpu_req_wdata(rq_d[g]),
        .cpu_rsp_valid(rs_v[g]), .cpu_rsp_ready(rs_r[g]), .cpu_rsp_rdata(rs_d[g]),
        .bus_req_o(breq[g]), .bus_gnt_i(bgnt[g]), .bus_cmd_o(cmd_o[g]),
        .bus_addr_o(addr_o[g]), .bus_data_o(dat_o[g]),
        .bus_valid_i(bvalid), .bus_cmd_i(bcmd), .bus_addr_i(baddr), .bus_data_i(bdata),
        .bus_shared_i(|bshr),
        .snp_shared_o(bshr[g]), .snp_supply_o(bsup[g]), .snp_data_o(sdat[g]));
    end
  end

  // bus environment: fixed priority, one-cycle transactions, memory
  always_comb begin
    bgnt   = breq & (~breq + 1'b1);
    bvalid = |bgnt;
    bcmd = '0; baddr = '0; bwdat = '0; supdat = '0;
    for (int i = 0; i < NC; i++) begin
      if (bgnt[i]) begin
        bcmd = cmd_o[i]; baddr = addr_o[i]; bwdat = dat_o[i];
      end
      if (bsup[i]) supdat = sdat[i];
    end
    bdata = (bcmd == 2'd1) ? (|bsup ? supdat : mem[baddr]) : bwdat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= DW'(i * 37 + 5);
      n_rd <= 0; n_upd <= 0; n_wb <= 0; bad_cmd <= 0; cyc <= 0;
    end else begin
      cyc <= cyc + 1;
      if (bvalid) begin
        if (bcmd == 2'd1) n_rd  <= n_rd + 1;
        if (bcmd == 2'd2) n_upd <= n_upd + 1;
        if (bcmd == 2'd3) begin
          n_wb <= n_wb + 1;
          mem[baddr] <= bwdat;
        end
      end
      for (int i = 0; i < NC; i++)
        if (cmd_o[i] != 2'd0 && !bgnt[i]) bad_cmd <= bad_cmd + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int c, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rd,
                       output int drd, output int dupd, output int dwb);
    int r0, u0, w0;
    logic [DW-1:0] first;
    r0 = n_rd; u0 = n_upd; w0 = n_wb;
    while (!rq_r[c] && cyc < LIMIT) @(negedge clk);
    rq_v[c] = 1'b1; rq_w[c] = wr; rq_a[c] = a; rq_d[c] = d;
    @(negedge clk);
    rq_v[c] = 1'b0;
    while (!rs_v[c] && cyc < LIMIT) @(negedge clk);
    first = rs_d[c];
    @(negedge clk);
    check(rs_v[c] && rs_d[c] == first, "R9 response held", int'(rs_d[c]), int'(first));
    rd = rs_d[c];
    rs_r[c] = 1'b1;
    @(negedge clk);
    rs_r[c] = 1'b0;
    drd = n_rd - r0; dupd = n_upd - u0; dwb = n_wb - w0;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int drd, dupd, dwb;
    for (int i = 0; i < NC; i++) begin
      rq_v[i] = 0; rq_w[i] = 0; rq_a[i] = '0; rq_d[i] = '0; rs_r[i] = 0;
    end
    for (int i = 0; i < 256; i++) gold[i] = DW'(i * 37 + 5);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    for (int i = 0; i < NC; i++)
      check(rq_r[i] && !rs_v[i] && !breq[i], "R1 reset state",
            {rq_r[i], rs_v[i], breq[i]}, 3'b100);

    foreach (VEC[k]) begin
      do_op(int'(VEC[k].c), VEC[k].wr, VEC[k].a, VEC[k].d, rd, drd, dupd, dwb);
      if (VEC[k].wr) gold[VEC[k].a] = VEC[k].d;
      check(rd == gold[VEC[k].a], $sformatf("R11 data vec %0d", k),
            int'(rd), int'(gold[VEC[k].a]));
      check(drd == int'(VEC[k].nrd) && dupd == int'(VEC[k].nupd) && dwb == int'(VEC[k].nwb),
            $sformatf("R2/R3/R4/R7/R8 traffic vec %0d", k),
            drd * 256 + dupd * 16 + dwb,
            int'(VEC[k].nrd) * 256 + int'(VEC[k].nupd) * 16 + int'(VEC[k].nwb));
    end

    // R1 first access of a fresh address in a fresh set misses
    do_op(1, 1'b0, 8'h23, '0, rd, drd, dupd, dwb);
    check(drd == 1 && rd == gold[8'h23], "R1 fresh miss", drd, 1);

    // R11 sweep: every cache sees the last written word
    foreach (VEC[k]) begin
      if (k < 3) begin
        for (int c = 0; c < NC; c++) begin
          logic [AW-1:0] a;
          a = (k == 0) ? 8'h10 : (k == 1) ? 8'h11 : 8'h14;
          do_op(c, 1'b0, a, '0, rd, drd, dupd, dwb);
          check(rd == gold[a], $sformatf("R11 sweep c%0d a%0h", c, a),
                int'(rd), int'(gold[a]));
        end
      end
    end

    check(bad_cmd == 0, "R10 command only under grant", bad_cmd, 0);
    if (cyc >= LIMIT) check(1'b0, "watchdog", cyc, LIMIT);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(LIMIT * 4 + 400);
    check(1'b0, "watchdog", LIMIT, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule